// File: doc/BRIEF.md
# Serial Receiver with Line-Break Wake Monitor

This block turns an asynchronous serial line into bytes. Each character has one start bit, eight data bits sent least significant bit first, and one stop bit. The block oversamples the line sixteen times per bit, and an external baud tick sets the sample rate. Each finished character goes into a holding register, raises a receive flag, and records whether the stop bit was valid. A read strobe takes the character and clears the flag.

Software can also arm a wake monitor. While the monitor is armed, the block decodes no characters and only watches the line. The first high-to-low transition on the line raises the receive flag and loads a dummy zero into the data register. The rising transition that follows disarms the monitor without software action, and normal reception then resumes. A line break or an all-zero character sent while the monitor is armed therefore yields one wake event and never a real byte.

Top module: `uart_rx_wake`

## Requirements
- R1: After reset, `wake_en`, `rx_flag` and `frame_err` are low and `rx_idle` is high.
- R2: A character is 1 low start bit, 8 data bits sent LSB first, and 1 stop bit, with each bit lasting 16 baud ticks. After the stop bit, `rd_data` holds the data bits and `rx_flag` is high.
- R3: `rx_idle` goes low when a start edge is detected. It stays low until the stop bit has been sampled at its middle.
- R4: If the stop bit samples low, `frame_err` goes high together with `rx_flag`. If the stop bit samples high, `frame_err` is low.
- R5: A pulse on `rd_strobe` clears `rx_flag` and `frame_err`. If a new event occurs in the same cycle, the new event wins.
- R6: A `wake_set` pulse while `rx_idle` is high sets `wake_en`. While `wake_en` is high, no character reception starts and `rx_idle` stays high.
- R7: While the monitor is armed, a falling edge on the line sets `rx_flag` and loads `rd_data` with 0x00 as dummy data.
- R8: The first rising edge after that falling edge clears `wake_en`. A 12-bit break or an all-zero character sent while the monitor is armed never sets `frame_err` and never delivers a byte.
- R9: Once `wake_en` has cleared, the next character is received normally.
- R10: A `wake_set` pulse while a reception is in progress is ignored. `wake_en` stays low and the character still completes.
- R11: The start bit is checked again at its middle, 8 ticks after the edge. If the line is high at that point, the receiver returns to idle with no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wake_set | input | 1 | Strobe that arms the wake monitor |
| wake_en | output | 1 | Wake monitor armed |
| rd_strobe | input | 1 | Read of the data register; clears the flags |
| rd_data | output | 8 | Received byte, or dummy zero after a wake event |
| rx_flag | output | 1 | Receive interrupt flag |
| rx_idle | output | 1 | High when no character is being received |
| frame_err | output | 1 | Stop bit of the last character was low |

## Verification
A wrong bit counter or mid-bit point shows up in `rd_data` within one character time. Such an error shifts or corrupts bits, or sets `frame_err` on a clean frame. If the wake monitor state is lost, the block does one of two wrong things. It decodes a break as a byte with a framing error, or it never drops `wake_en` after the line returns high. Both are visible within a few clock cycles of the rising edge. A receive path that is not properly blocked while armed shows up as `rx_idle` going low during a break.

// File: rtl/rxw_pkg.sv
// Shared types for the serial receiver with wake monitor.
// Assumes nothing beyond a single clock domain for the consumers.
package rxw_pkg;

    // Receive framer phases
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_DATA  = 2'd2,
        FR_STOP  = 2'd3
    } fr_state_t;

endpackage

// File: rtl/rxw_sync.sv
// Brings the asynchronous line into the clock domain and reports edges.
// Assumes the line idles high; all stages reset to 1 so no false edge
// follows reset.
module rxw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic line_fall,
    output logic line_rise
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchronizer chain and one-cycle history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], line_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign line_s    = sync_q[STAGES-1];
    assign line_fall = prev_q & ~line_s;
    assign line_rise = ~prev_q & line_s;

endmodule

// File: rtl/rxw_frame.sv
// Character framer: start validation at mid-bit, data shift LSB first,
// stop sampling. Assumes tick pulses at OSR times the bit rate and a
// synchronized line. 'inhibit' blocks any new start detection.
module rxw_frame
    import rxw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_s,
    input  logic              line_fall,
    input  logic              inhibit,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] word,
    output logic              stop_ok
);

    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OSR - 1);
    localparam logic [BIT_W-1:0] TOP_B  = BIT_W'(DATA_W - 1);

    fr_state_t         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  nbit_q;
    logic [DATA_W-1:0] shift_q;

    // Framer sequence: detect, validate, shift, sample stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            cnt_q   <= '0;
            nbit_q  <= '0;
            shift_q <= '0;
            done    <= 1'b0;
            stop_ok <= 1'b1;
        end else begin
            done <= 1'b0;
            case (state_q)
                FR_IDLE: begin
                    if (line_fall && !inhibit) begin
                        state_q <= FR_START;
                        cnt_q   <= '0;
                    end
                end
                FR_START: begin
                    if (tick) begin
                        if (cnt_q == MID_C) begin
                            cnt_q  <= '0;
                            nbit_q <= '0;
                            state_q <= line_s ? FR_IDLE : FR_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                FR_DATA: begin
                    if (tick) begin
                        if (cnt_q == LAST_C) begin
                            cnt_q   <= '0;
                            shift_q <= {line_s, shift_q[DATA_W-1:1]};
                            if (nbit_q == TOP_B) begin
                                state_q <= FR_STOP;
                            end else begin
                                nbit_q <= nbit_q + 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                FR_STOP: begin
                    if (tick) begin
                        if (cnt_q == LAST_C) begin
                            cnt_q   <= '0;
                            done    <= 1'b1;
                            stop_ok <= line_s;
                            state_q <= FR_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= FR_IDLE;
            endcase
        end
    end

    assign busy = (state_q != FR_IDLE);
    assign word = shift_q;

endmodule

// File: rtl/rxw_wake.sv
// Wake monitor: armed by software when the framer is idle, reports the
// first falling edge as a wake event, disarms on the next rising edge.
// Assumes edge pulses come from the synchronized line.
module rxw_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic rx_busy,
    input  logic line_fall,
    input  logic line_rise,
    output logic armed,
    output logic wake_evt
);

    logic fell_q;

    // Arm, wait for falling edge, then self-clear on the rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            fell_q <= 1'b0;
        end else if (!armed) begin
            if (arm_req && !rx_busy) begin
                armed  <= 1'b1;
                fell_q <= 1'b0;
            end
        end else if (!fell_q) begin
            if (line_fall) begin
                fell_q <= 1'b1;
            end
        end else if (line_rise) begin
            armed  <= 1'b0;
            fell_q <= 1'b0;
        end
    end

    assign wake_evt = armed & ~fell_q & line_fall;

endmodule

// File: rtl/uart_rx_wake.sv
// Serial receiver top: synchronizer, framer, wake monitor and the
// software-visible holding registers. Assumes baud_tick is a one-cycle
// pulse at OSR times the bit rate and rd_strobe is a one-cycle pulse.
module uart_rx_wake #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              baud_tick,
    input  logic              wake_set,
    output logic              wake_en,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_flag,
    output logic              rx_idle,
    output logic              frame_err
);

    logic              line_s, line_fall, line_rise;
    logic              fr_busy, fr_done, fr_stop_ok;
    logic [DATA_W-1:0] fr_word;
    logic              wake_evt;
    logic              armed;

    rxw_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (rx_in),
        .line_s    (line_s),
        .line_fall (line_fall),
        .line_rise (line_rise)
    );

    rxw_frame #(.DATA_W(DATA_W), .OSR(OSR)) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .line_s    (line_s),
        .line_fall (line_fall),
        .inhibit   (armed | wake_set),
        .busy      (fr_busy),
        .done      (fr_done),
        .word      (fr_word),
        .stop_ok   (fr_stop_ok)
    );

    rxw_wake i_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_req   (wake_set),
        .rx_busy   (fr_busy),
        .line_fall (line_fall),
        .line_rise (line_rise),
        .armed     (armed),
        .wake_evt  (wake_evt)
    );

    // Holding registers: new events take priority over a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data   <= '0;
            rx_flag   <= 1'b0;
            frame_err <= 1'b0;
        end else if (fr_done) begin
            rd_data   <= fr_word;
            rx_flag   <= 1'b1;
            frame_err <= ~fr_stop_ok;
        end else if (wake_evt) begin
            rd_data   <= '0;
            rx_flag   <= 1'b1;
        end else if (rd_strobe) begin
            rx_flag   <= 1'b0;
            frame_err <= 1'b0;
        end
    end

    assign wake_en = armed;
    assign rx_idle = ~fr_busy;

endmodule

// File: rtl/rxw_checker.sv
// Temporal checks on the receiver, attached by bind to every instance.
module rxw_checker (
    input logic clk,
    input logic rst_n,
    input logic line_rise,
    input logic wake_en,
    input logic wake_evt,
    input logic fr_done,
    input logic rd_strobe,
    input logic wake_set,
    input logic rx_flag,
    input logic rx_idle,
    input logic frame_err
);

    // R6: armed monitor keeps the framer idle
    p_armed_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_en |-> rx_idle);

    // R7: wake event raises the flag on the next cycle
    p_wake_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> rx_flag);

    // R8: disarm only follows a rising line edge
    p_disarm_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_en && !line_rise) |=> wake_en);

    // R5: a read with no competing event clears the flag
    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !fr_done && !wake_evt) |=> !rx_flag);

    // R10: no arming while a character is in progress
    p_busy_noarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_idle && !wake_en) |=> !wake_en);

    // R4: framing error never appears without the receive flag
    p_ferr_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> rx_flag);

endmodule

bind uart_rx_wake rxw_checker i_rxw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_rise (line_rise),
    .wake_en   (wake_en),
    .wake_evt  (wake_evt),
    .fr_done   (fr_done),
    .rd_strobe (rd_strobe),
    .wake_set  (wake_set),
    .rx_flag   (rx_flag),
    .rx_idle   (rx_idle),
    .frame_err (frame_err)
);

// File: tb/test_uart_rx_wake.sv
// Directed bench: one task per scenario, each checking its own results.
module test_uart_rx_wake;

    localparam int TICK_DIV = 4;
    localparam int BIT_CLK  = TICK_DIV * 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       baud_tick = 1'b0;
    logic       wake_set = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       wake_en, rx_flag, rx_idle, frame_err;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    uart_rx_wake i_uart_rx_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_in     (rx_in),
        .baud_tick (baud_tick),
        .wake_set  (wake_set),
        .wake_en   (wake_en),
        .rd_strobe (rd_strobe),
        .rd_data   (rd_data),
        .rx_flag   (rx_flag),
        .rx_idle   (rx_idle),
        .frame_err (frame_err)
    );

    // Baud tick source: one pulse every TICK_DIV clocks
    initial begin
        int n = 0;
        forever begin
            @(negedge clk);
            n = (n == TICK_DIV - 1) ? 0 : n + 1;
            baud_tick = (n == TICK_DIV - 1);
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk) wake_set = 1'b1;
        @(negedge clk) wake_set = 1'b0;
    endtask

    // Sends one 8N1 frame; poke 1 checks rx_idle, poke 2 tries to arm
    task automatic send(logic [7:0] b, logic stop, int poke);
        @(negedge clk) rx_in = 1'b0;
        hold(BIT_CLK);
        for (int i = 0; i < 8; i++) begin
            rx_in = b[i];
            if (i == 3 && poke != 0) begin
                hold(BIT_CLK / 2);
                if (poke == 1) check("R3 rx_idle mid-frame", rx_idle, 0);
                else pulse_wake();
                hold(BIT_CLK / 2 - (poke == 2 ? 2 : 0));
            end else begin
                hold(BIT_CLK);
            end
        end
        rx_in = stop;
        hold(BIT_CLK);
        rx_in = 1'b1;
        hold(8);
    endtask

    task automatic t_reset();
        check("R1 wake_en", wake_en, 0);
        check("R1 rx_flag", rx_flag, 0);
        check("R1 frame_err", frame_err, 0);
        check("R1 rx_idle", rx_idle, 1);
    endtask

    task automatic t_bytes();
        logic [7:0] pats [3] = '{8'hA5, 8'h3C, 8'h81};
        foreach (pats[k]) begin
            send(pats[k], 1'b1, k == 0 ? 1 : 0);
            check("R2 rd_data", rd_data, pats[k]);
            check("R2 rx_flag", rx_flag, 1);
            check("R4 frame_err clean stop", frame_err, 0);
            check("R3 rx_idle after stop", rx_idle, 1);
            do_read();
            check("R5 rx_flag after read", rx_flag, 0);
        end
    endtask

    task automatic t_framing();
        send(8'h6E, 1'b0, 0);
        check("R4 frame_err set", frame_err, 1);
        check("R4 rx_flag", rx_flag, 1);
        check("R2 rd_data", rd_data, 8'h6E);
        do_read();
        check("R5 frame_err cleared", frame_err, 0);
        check("R5 rx_flag cleared", rx_flag, 0);
        hold(BIT_CLK);
    endtask

    task automatic t_glitch();
        @(negedge clk) rx_in = 1'b0;
        hold(16);
        rx_in = 1'b1;
        hold(2 * BIT_CLK);
        check("R11 rx_flag after glitch", rx_flag, 0);
        check("R11 rx_idle after glitch", rx_idle, 1);
    endtask

    task automatic t_break();
        pulse_wake();
        hold(2);
        check("R6 wake_en armed", wake_en, 1);
        @(negedge clk) rx_in = 1'b0;
        hold(8);
        check("R7 rx_flag on fall", rx_flag, 1);
        check("R7 rd_data dummy", rd_data, 0);
        hold(12 * BIT_CLK);
        check("R8 wake_en held while low", wake_en, 1);
        check("R6 rx_idle while armed", rx_idle, 1);
        rx_in = 1'b1;
        hold(8);
        check("R8 wake_en self-clear", wake_en, 0);
        check("R8 no frame_err", frame_err, 0);
        do_read();
        check("R5 rx_flag after read", rx_flag, 0);
        hold(BIT_CLK);
        send(8'h5A, 1'b1, 0);
        check("R9 resume rd_data", rd_data, 8'h5A);
        check("R9 resume rx_flag", rx_flag, 1);
        do_read();
    endtask

    task automatic t_zero_char();
        pulse_wake();
        send(8'h00, 1'b1, 0);
        check("R8 wake_en cleared after zero char", wake_en, 0);
        check("R8 rd_data dummy", rd_data, 0);
        check("R8 frame_err", frame_err, 0);
        check("R7 rx_flag", rx_flag, 1);
        do_read();
        hold(BIT_CLK);
        send(8'hC3, 1'b1, 0);
        check("R9 resume rd_data", rd_data, 8'hC3);
        do_read();
    endtask

    task automatic t_busy_arm();
        send(8'h27, 1'b1, 2);
        check("R10 wake_en stays low", wake_en, 0);
        check("R10 byte completes", rd_data, 8'h27);
        check("R10 rx_flag", rx_flag, 1);
        do_read();
    endtask

    initial begin
        hold(5);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        hold(BIT_CLK);
        t_reset();
        t_bytes();
        t_framing();
        t_glitch();
        t_break();
        t_zero_char();
        t_busy_arm();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule